// File: doc/BRIEF.md
# Sample Stamp Timing Generator

This block timestamps audio samples against a fast reference clock. A fast counter counts reference-clock cycles and restarts at every rising edge of the asynchronous word clock. A word counter counts those edges modulo the audio buffer size. Together the two counters give the position of any event as "word index plus fraction of a word period". The block keeps the length of the most recent word-clock period and the shortest period seen since software last cleared it. A short period that appears in the minimum register points to a spurious word-clock pulse.

Software can load the word counter with a value or add an offset to it. An add that lands in the same cycle as a word-clock edge still counts that edge. An external event latches both counters together into a capture pair. Reading the word counter latches the fast counter in the same cycle, so the two values read are coherent. Each of the input and output audio streams has a ready flag and a trigger value. When an armed stream's trigger matches the word counter, the block emits a one-cycle start strobe and drops the ready flag. A sticky flag reports a word clock that has stopped.

Top module: `sstamp_gen`

## Requirements
- R1: The word clock passes through a two-flop synchronizer, and a rising edge is detected in the reference domain. The edge is acted on at the third reference-clock edge after the word clock is first sampled high. While enabled, the fast counter reads 0 in the cycle after that edge and otherwise increments by one per cycle.
- R2: At each detected edge, the value the fast counter would have reached is stored as the last period. That value is the current count plus one, saturated at 0xFFFF.
- R3: The fast counter saturates at 0xFFFF instead of wrapping.
- R4: Each newly stored period is copied into the minimum-period register if it is smaller than the register's contents. A minimum-reset pulse sets the register to 0xFFFF and takes priority over any update in the same cycle.
- R5: The word counter increments on each detected edge and wraps to 0 when it reaches the modulo input. A modulo of 0 gives the full 16-bit range.
- R6: A set command loads the word counter with the command value and takes priority over add and edge. An add command gives (counter + value + edge) reduced by the modulo. A negative step is made by adding the modulo minus the amount.
- R7: A capture event latches the current fast and word counter values into the capture pair one cycle later.
- R8: A word-counter read pulse latches the current fast counter value into the read-latch output.
- R9: While the enable is low, the fast counter, word counter, last period, capture pair, read latch, ready flags and start strobes are 0, and the minimum period is 0xFFFF.
- R10: An arm pulse raises a stream's ready flag. If the flag is high and the word counter equals that stream's trigger value, the next cycle shows a one-cycle start strobe with the ready flag low. Lane 0 is the input stream and lane 1 is the output stream.
- R11: The stall flag sets when the fast counter equals 65535, which means 65535 cycles without an edge. A clear pulse resets the flag, but a set condition in the same cycle wins. Dropping the enable does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator enable; low clears counters and captures |
| wclk_in | input | 1 | Asynchronous word clock |
| period_mod | input | 16 | Word counter modulo (buffer size), 0 = full range |
| in_trig | input | 16 | Word count that starts the input stream |
| out_trig | input | 16 | Word count that starts the output stream |
| in_arm | input | 1 | Pulse: input stream ready |
| out_arm | input | 1 | Pulse: output stream ready |
| wset | input | 1 | Pulse: load word counter |
| wadd | input | 1 | Pulse: add to word counter |
| wadj_value | input | 16 | Operand of set/add |
| minper_reset | input | 1 | Pulse: minimum period back to 0xFFFF |
| capt_evt | input | 1 | External capture event |
| wcnt_read | input | 1 | Pulse: word counter is being read |
| timeout_clr | input | 1 | Pulse: clear stall flag |
| fast_cnt | output | 16 | Current fast counter |
| word_cnt | output | 16 | Current word counter |
| last_period | output | 16 | Most recent word-clock period |
| min_period | output | 16 | Smallest period since last minimum reset |
| capt_fast | output | 16 | Captured fast counter |
| capt_word | output | 16 | Captured word counter |
| read_fast | output | 16 | Fast counter latched by a read |
| in_ready | output | 1 | Input stream armed |
| out_ready | output | 1 | Output stream armed |
| in_start | output | 1 | Input stream start strobe |
| out_start | output | 1 | Output stream start strobe |
| timeout_flag | output | 1 | Sticky stalled-word-clock flag |

## Verification
Every state element of this block is a visible output, and each updates one cycle after its cause. A wrong fast-counter restart or a wrong synchronizer depth therefore shows as a count mismatch on the next cycle. A wrong wrap, add reduction or set priority shows on the word counter at the first affected edge. A missed compare shows as a start strobe in the wrong cycle or a ready flag that stays high. Any divergence in the stall logic shows only after the 65535-cycle stall window, so one full stall is run, followed by a clear attempted while the stall persists.

// File: rtl/sstamp_pkg.sv
package sstamp_pkg;
  localparam int unsigned N_LANES  = 2;
  localparam int unsigned LANE_IN  = 0;
  localparam int unsigned LANE_OUT = 1;

  typedef enum logic [1:0] {
    WCMD_NONE = 2'd0,
    WCMD_SET  = 2'd1,
    WCMD_ADD  = 2'd2
  } wcmd_e;
endpackage

// File: rtl/sstamp_sync.sv
module sstamp_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] pipe_q, pipe_n;

  always_comb begin
    pipe_n = {pipe_q[1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 3'b000;
    else        pipe_q <= pipe_n;
  end

  assign rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/sstamp_fast.sv
module sstamp_fast #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned STALL_LIMIT = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise,
  input  logic             min_clr,
  input  logic             stall_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] last_per,
  output logic [CNT_W-1:0] min_per,
  output logic             stall
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STALL_LIMIT);

  logic [CNT_W-1:0] count_n, last_n, min_n, reach;
  logic             stall_n;

  always_comb begin
    reach   = (count == CNT_MAX) ? CNT_MAX : count + 1'b1;
    count_n = count;
    last_n  = last_per;
    min_n   = min_per;
    if (!en) begin
      count_n = '0;
      last_n  = '0;
      min_n   = CNT_MAX;
    end else begin
      if (rise) begin
        count_n = '0;
        last_n  = reach;
        if (reach < min_per) min_n = reach;
      end else begin
        count_n = reach;
      end
      if (min_clr) min_n = CNT_MAX;
    end
  end

  always_comb begin
    stall_n = stall;
    if (stall_clr) stall_n = 1'b0;
    if (en && (count == LIMIT_V)) stall_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      last_per <= '0;
      min_per  <= CNT_MAX;
      stall    <= 1'b0;
    end else begin
      count    <= count_n;
      last_per <= last_n;
      min_per  <= min_n;
      stall    <= stall_n;
    end
  end
endmodule

// File: rtl/sstamp_word.sv
module sstamp_word
  import sstamp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise,
  input  wcmd_e            cmd,
  input  logic [CNT_W-1:0] operand,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] count_n, step;
  logic             mod_on;

  always_comb begin
    mod_on  = (modulo != '0);
    step    = (cmd == WCMD_ADD) ? operand : '0;
    sum     = {1'b0, count} + {1'b0, step} + {{CNT_W{1'b0}}, rise};
    count_n = count;
    if (!en) begin
      count_n = '0;
    end else if (cmd == WCMD_SET) begin
      count_n = operand;
    end else if ((cmd == WCMD_ADD) || rise) begin
      if (mod_on && (sum >= {1'b0, modulo})) count_n = CNT_W'(sum - {1'b0, modulo});
      else                                  count_n = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end
endmodule

// File: rtl/sstamp_trig.sv
module sstamp_trig #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  logic [CNT_W-1:0] trig_val,
  input  logic [CNT_W-1:0] word,
  output logic             ready,
  output logic             start
);
  logic ready_n, start_n, hit;

  always_comb begin
    hit     = ready && (word == trig_val);
    start_n = 1'b0;
    ready_n = ready;
    if (!en) begin
      ready_n = 1'b0;
    end else if (hit) begin
      start_n = 1'b1;
      ready_n = 1'b0;
    end else if (arm) begin
      ready_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      start <= 1'b0;
    end else begin
      ready <= ready_n;
      start <= start_n;
    end
  end
endmodule

// File: rtl/sstamp_gen.sv
module sstamp_gen
  import sstamp_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned STALL_LIMIT = 65535
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wclk_in,
  input  logic [CNT_W-1:0] period_mod,
  input  logic [CNT_W-1:0] in_trig,
  input  logic [CNT_W-1:0] out_trig,
  input  logic             in_arm,
  input  logic             out_arm,
  input  logic             wset,
  input  logic             wadd,
  input  logic [CNT_W-1:0] wadj_value,
  input  logic             minper_reset,
  input  logic             capt_evt,
  input  logic             wcnt_read,
  input  logic             timeout_clr,
  output logic [CNT_W-1:0] fast_cnt,
  output logic [CNT_W-1:0] word_cnt,
  output logic [CNT_W-1:0] last_period,
  output logic [CNT_W-1:0] min_period,
  output logic [CNT_W-1:0] capt_fast,
  output logic [CNT_W-1:0] capt_word,
  output logic [CNT_W-1:0] read_fast,
  output logic             in_ready,
  output logic             out_ready,
  output logic             in_start,
  output logic             out_start,
  output logic             timeout_flag
);
  logic                         wedge;
  wcmd_e                        cmd;
  logic [N_LANES-1:0]           lane_arm, lane_ready, lane_start;
  logic [N_LANES-1:0][CNT_W-1:0] lane_trig;
  logic [CNT_W-1:0]             capt_fast_n, capt_word_n, read_fast_n;

  sstamp_sync i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wclk_in),
    .rise     (wedge)
  );

  sstamp_fast #(.CNT_W(CNT_W), .STALL_LIMIT(STALL_LIMIT)) i_fast (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .rise      (wedge),
    .min_clr   (minper_reset),
    .stall_clr (timeout_clr),
    .count     (fast_cnt),
    .last_per  (last_period),
    .min_per   (min_period),
    .stall     (timeout_flag)
  );

  always_comb begin
    if (wset)      cmd = WCMD_SET;
    else if (wadd) cmd = WCMD_ADD;
    else           cmd = WCMD_NONE;
  end

  sstamp_word #(.CNT_W(CNT_W)) i_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .rise    (wedge),
    .cmd     (cmd),
    .operand (wadj_value),
    .modulo  (period_mod),
    .count   (word_cnt)
  );

  assign lane_arm[LANE_IN]   = in_arm;
  assign lane_arm[LANE_OUT]  = out_arm;
  assign lane_trig[LANE_IN]  = in_trig;
  assign lane_trig[LANE_OUT] = out_trig;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    sstamp_trig #(.CNT_W(CNT_W)) i_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (enable),
      .arm      (lane_arm[g]),
      .trig_val (lane_trig[g]),
      .word     (word_cnt),
      .ready    (lane_ready[g]),
      .start    (lane_start[g])
    );
  end

  assign in_ready  = lane_ready[LANE_IN];
  assign out_ready = lane_ready[LANE_OUT];
  assign in_start  = lane_start[LANE_IN];
  assign out_start = lane_start[LANE_OUT];

  always_comb begin
    capt_fast_n = capt_fast;
    capt_word_n = capt_word;
    read_fast_n = read_fast;
    if (!enable) begin
      capt_fast_n = '0;
      capt_word_n = '0;
      read_fast_n = '0;
    end else begin
      if (capt_evt) begin
        capt_fast_n = fast_cnt;
        capt_word_n = word_cnt;
      end
      if (wcnt_read) read_fast_n = fast_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_fast <= '0;
      capt_word <= '0;
      read_fast <= '0;
    end else begin
      capt_fast <= capt_fast_n;
      capt_word <= capt_word_n;
      read_fast <= read_fast_n;
    end
  end
endmodule

// File: rtl/sstamp_gen_chk.sv
module sstamp_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             wedge,
  input logic             wset,
  input logic             wadd,
  input logic [CNT_W-1:0] wadj_value,
  input logic [CNT_W-1:0] period_mod,
  input logic             minper_reset,
  input logic             capt_evt,
  input logic             timeout_clr,
  input logic [CNT_W-1:0] fast_cnt,
  input logic [CNT_W-1:0] word_cnt,
  input logic [CNT_W-1:0] last_period,
  input logic [CNT_W-1:0] min_period,
  input logic [CNT_W-1:0] capt_fast,
  input logic [CNT_W-1:0] capt_word,
  input logic             in_ready,
  input logic             out_ready,
  input logic             in_start,
  input logic             out_start,
  input logic             timeout_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_fast_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wedge) |=> (fast_cnt == '0));

  a_r2_last_period: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wedge && (fast_cnt != CNT_MAX)) |=> (last_period == $past(fast_cnt) + 1'b1));

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !wedge && (fast_cnt == CNT_MAX)) |=> (fast_cnt == CNT_MAX));

  a_r4_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wedge && !minper_reset) |=> (min_period <= last_period));

  a_r4_min_reset: assert property (@(posedge clk) disable iff (!rst_n)
    minper_reset |=> (min_period == CNT_MAX));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wedge && !wset && !wadd && (period_mod != '0) &&
     (word_cnt == period_mod - 1'b1)) |=> (word_cnt == '0));

  a_r6_set_load: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wset) |=> (word_cnt == $past(wadj_value)));

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && capt_evt) |=> ((capt_word == $past(word_cnt)) && (capt_fast == $past(fast_cnt))));

  a_r9_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((fast_cnt == '0) && (word_cnt == '0) && (capt_fast == '0) && (capt_word == '0)));

  a_r10_in_start: assert property (@(posedge clk) disable iff (!rst_n)
    in_start |-> !in_ready);

  a_r10_out_start: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> !out_ready);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !timeout_clr) |=> timeout_flag);
endmodule

bind sstamp_gen sstamp_gen_chk #(.CNT_W(CNT_W)) i_sstamp_gen_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .wedge        (wedge),
  .wset         (wset),
  .wadd         (wadd),
  .wadj_value   (wadj_value),
  .period_mod   (period_mod),
  .minper_reset (minper_reset),
  .capt_evt     (capt_evt),
  .timeout_clr  (timeout_clr),
  .fast_cnt     (fast_cnt),
  .word_cnt     (word_cnt),
  .last_period  (last_period),
  .min_period   (min_period),
  .capt_fast    (capt_fast),
  .capt_word    (capt_word),
  .in_ready     (in_ready),
  .out_ready    (out_ready),
  .in_start     (in_start),
  .out_start    (out_start),
  .timeout_flag (timeout_flag)
);

// File: tb/test_sstamp_gen.sv
module test_sstamp_gen;
  logic        clk, rst_n, enable, wclk_in;
  logic [15:0] period_mod, in_trig, out_trig, wadj_value;
  logic        in_arm, out_arm, wset, wadd, minper_reset, capt_evt, wcnt_read, timeout_clr;
  logic [15:0] fast_cnt, word_cnt, last_period, min_period, capt_fast, capt_word, read_fast;
  logic        in_ready, out_ready, in_start, out_start, timeout_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  sstamp_gen i_sstamp_gen (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // word clock generator
  bit wrun = 0;
  int whalf = 10;
  initial begin
    int cnt;
    cnt = 0;
    wclk_in = 1'b0;
    forever begin
      @(negedge clk);
      if (wrun) begin
        cnt++;
        if (cnt >= whalf) begin
          wclk_in = ~wclk_in;
          cnt = 0;
        end
      end
    end
  end

  // behavioural reference model
  bit          d1, d2, d3, ed;
  int          m_fast, m_word, m_last, m_min, m_cf, m_cw, m_rd;
  bit          m_ir, m_or, m_is, m_os, m_to;
  int          nf, nw, nl, nm, ncf, ncw, nrd, reach, s;
  bit          nir, nor_, nis, nos, nto;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 = 0; d2 = 0; d3 = 0;
      m_fast = 0; m_word = 0; m_last = 0; m_min = 65535;
      m_cf = 0; m_cw = 0; m_rd = 0;
      m_ir = 0; m_or = 0; m_is = 0; m_os = 0; m_to = 0;
    end else begin
      ed = d2 && !d3;
      d3 = d2; d2 = d1; d1 = wclk_in;
      nto = m_to;
      if (timeout_clr) nto = 0;
      if (enable && m_fast == 65535) nto = 1;
      if (!enable) begin
        nf = 0; nw = 0; nl = 0; nm = 65535; ncf = 0; ncw = 0; nrd = 0;
        nir = 0; nor_ = 0; nis = 0; nos = 0;
      end else begin
        reach = (m_fast == 65535) ? 65535 : m_fast + 1;
        nl = m_last; nm = m_min;
        if (ed) begin
          nf = 0; nl = reach;
          if (reach < m_min) nm = reach;
        end else nf = reach;
        if (minper_reset) nm = 65535;
        nw = m_word;
        if (wset) nw = wadj_value;
        else if (wadd || ed) begin
          s = m_word + (wadd ? int'(wadj_value) : 0) + (ed ? 1 : 0);
          nw = (period_mod != 0) ? s % int'(period_mod) : s % 65536;
        end
        ncf = capt_evt ? m_fast : m_cf;
        ncw = capt_evt ? m_word : m_cw;
        nrd = wcnt_read ? m_fast : m_rd;
        nis = m_ir && (m_word == in_trig);
        nos = m_or && (m_word == out_trig);
        nir = nis ? 0 : (in_arm ? 1 : m_ir);
        nor_ = nos ? 0 : (out_arm ? 1 : m_or);
      end
      m_fast = nf; m_word = nw; m_last = nl; m_min = nm;
      m_cf = ncf; m_cw = ncw; m_rd = nrd;
      m_ir = nir; m_or = nor_; m_is = nis; m_os = nos; m_to = nto;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R3 R9 fast_cnt", int'(fast_cnt), m_fast);
      chk("R5 R6 R9 word_cnt", int'(word_cnt), m_word);
      chk("R2 last_period", int'(last_period), m_last);
      chk("R4 min_period", int'(min_period), m_min);
      chk("R7 capt_fast", int'(capt_fast), m_cf);
      chk("R7 capt_word", int'(capt_word), m_cw);
      chk("R8 read_fast", int'(read_fast), m_rd);
      chk("R10 in_ready", int'(in_ready), int'(m_ir));
      chk("R10 out_ready", int'(out_ready), int'(m_or));
      chk("R10 in_start", int'(in_start), int'(m_is));
      chk("R10 out_start", int'(out_start), int'(m_os));
      chk("R11 timeout_flag", int'(timeout_flag), int'(m_to));
    end
  end

  // 0 set,1 add,2 capture,3 read,4 min reset,5 arm in,6 arm out,7 stall clear
  task automatic cmd(input int which, input logic [15:0] v);
    @(negedge clk);
    wadj_value = v;
    case (which)
      0: wset = 1; 1: wadd = 1; 2: capt_evt = 1; 3: wcnt_read = 1;
      4: minper_reset = 1; 5: in_arm = 1; 6: out_arm = 1; default: timeout_clr = 1;
    endcase
    @(negedge clk);
    wset = 0; wadd = 0; capt_evt = 0; wcnt_read = 0;
    minper_reset = 0; in_arm = 0; out_arm = 0; timeout_clr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; enable = 0; period_mod = 16'd8; in_trig = 16'd5; out_trig = 16'd2;
    wadj_value = 0; in_arm = 0; out_arm = 0; wset = 0; wadd = 0;
    minper_reset = 0; capt_evt = 0; wcnt_read = 0; timeout_clr = 0;
    idle(3);
    // R9 reset state
    chk("R9 reset fast", int'(fast_cnt), 0);
    chk("R4 reset min", int'(min_period), 65535);
    rst_n = 1;
    idle(2);
    enable = 1;
    whalf = 10; wrun = 1;
    idle(200);
    chk("R2 period 20", int'(last_period), 20);
    // R4 shorter then longer period
    whalf = 6; idle(100);
    whalf = 15; idle(150);
    chk("R4 min keeps 12", int'(min_period), 12);
    cmd(4, 16'h1234);
    idle(80);
    chk("R4 min after reset", int'(min_period), 30);
    // R7 / R8
    cmd(2, 0); idle(7); cmd(3, 0); idle(13); cmd(2, 0);
    // R6 set and adds, incl. negative step and adds near edges
    cmd(0, 16'd3); idle(5);
    cmd(1, 16'd6); idle(9);
    cmd(1, 16'd8 - 16'd2);
    whalf = 2;
    for (int i = 0; i < 12; i++) begin cmd(1, 16'(i % 8)); idle(i % 3); end
    whalf = 10;
    idle(60);
    // R10 triggers
    cmd(5, 0); cmd(6, 0);
    idle(400);
    chk("R10 in ready dropped", int'(in_ready), 0);
    chk("R10 out ready dropped", int'(out_ready), 0);
    in_trig = 16'd7; cmd(5, 0); cmd(1, 16'd1); idle(300);
    // R5 full-range modulo
    period_mod = 16'd0; cmd(0, 16'hFFFD); idle(150);
    chk("R5 full range wrap", int'(word_cnt < 16'd10), 1);
    period_mod = 16'd8;
    cmd(0, 16'd1);
    // R9 disable clears
    cmd(2, 0); cmd(5, 0);
    enable = 0; idle(4);
    chk("R9 fast cleared", int'(fast_cnt), 0);
    chk("R9 word cleared", int'(word_cnt), 0);
    chk("R9 capture cleared", int'(capt_word), 0);
    chk("R9 ready cleared", int'(in_ready), 0);
    cmd(5, 0);
    chk("R9 arm ignored", int'(in_ready), 0);
    enable = 1; idle(50);
    // R11 / R3 stall
    wrun = 0; wclk_in = 0;
    idle(65545);
    chk("R3 saturated", int'(fast_cnt), 65535);
    chk("R11 stall set", int'(timeout_flag), 1);
    cmd(7, 0);
    chk("R11 clear loses to set", int'(timeout_flag), 1);
    wrun = 1; idle(40);
    cmd(7, 0); idle(2);
    chk("R11 cleared", int'(timeout_flag), 0);
    enable = 0; idle(3);
    idle(2);
    finish_run();
  end
endmodule